// File: doc/BRIEF.md
# Four-Channel PWM Generator with Boundary-Synchronised Reload

This block produces four independent pulse-width-modulated outputs. Software programs each channel through a small register bank on a single-cycle APB-style bus. Each channel has two 32-bit counts, both measured in bus-clock cycles. The high-time count sets how long the output stays high at the start of each period. The period count sets the length of one full cycle.

Software writes into shadow registers. A running channel copies its shadow values into its working copy only when the current period finishes, so a waveform never shows a partial update. A channel whose working period count is zero is stopped and holds its output high. A stopped channel starts on the next clock once it sees a nonzero shadow period.

Top module: `quad_pwm`

## Requirements
- R1: After reset every register reads 0 and every bit of `pwm_o` is 1.
- R2: Channel c's high-time register sits at byte offset 8*c and its period register at 8*c+4. A write happens on a clock edge where `psel_i`, `penable_i` and `pwrite_i` are all 1. While `psel_i`=1 and `pwrite_i`=0, `prdata_o` returns the addressed shadow value combinationally; at all other times it is 0.
- R3: An offset with `paddr_i[1:0]` not equal to 0 reads as 0, and a write to it changes no register and no output.
- R4: A channel whose working period is 0 is stopped and drives its output high. Writing 0 to both registers of a running channel stops it once its current period ends.
- R5: A stopped channel that holds a nonzero shadow period loads both shadow values on the next clock edge and starts its first period with count 0.
- R6: A running channel counts 0 to P-1 and then wraps. Its output is 1 while the count is below H and 0 otherwise, so each period gives H high cycles followed by P-H low cycles.
- R7: A write to a running channel does not change the waveform until the count wraps; the new values apply from the next period on. A read returns the new value at once.
- R8: With H >= P the output stays 1 for the whole period; with H = 0 and P nonzero the output stays 0.
- R9: Writing and running one channel has no effect on the outputs or registers of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access enable |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 5 | Byte offset |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, shadow value or 0 |
| pwm_o | output | 4 | One waveform per channel |

## Verification
The assertions assume a bus master that raises `psel_i` and `penable_i` together for exactly one cycle per write. They also assume the address and data stay steady during that cycle.

The bench drives every access this way. It changes bus signals only at falling edges and takes each read value within the same low half-cycle. To start a channel, it writes the high-time register before the period register, so the channel never loads a half-written pair.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W = 32;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] per;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          psel_i,
  input  logic                          penable_i,
  input  logic                          pwrite_i,
  input  logic [ADDR_W-1:0]             paddr_i,
  input  logic [CNT_W-1:0]              pwdata_i,
  output logic [CNT_W-1:0]              prdata_o,
  output pwm_cfg_t [NUM_CH-1:0]         shadow_o
);
  localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned IDX_LSB  = 3;

  logic                hi_ok;
  logic                aligned;
  logic                sel_per;
  logic [CH_IDX_W-1:0] ch_idx;
  logic                wr_en;
  logic                rd_en;
  pwm_cfg_t [NUM_CH-1:0] sh_q;

  assign aligned = (paddr_i[1:0] == 2'b00);
  assign sel_per = paddr_i[2];
  assign ch_idx  = paddr_i[IDX_LSB +: CH_IDX_W];

  generate
    if (ADDR_W > IDX_LSB + CH_IDX_W) begin : g_hi_chk
      assign hi_ok = (paddr_i[ADDR_W-1:IDX_LSB+CH_IDX_W] == '0);
    end else begin : g_hi_none
      assign hi_ok = 1'b1;
    end
  endgenerate

  assign wr_en = psel_i & penable_i & pwrite_i & aligned & hi_ok;
  assign rd_en = psel_i & ~pwrite_i & aligned & hi_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == CH_IDX_W'(i)) begin
          if (sel_per) sh_q[i].per <= pwdata_i;
          else         sh_q[i].hi  <= pwdata_i;
        end
      end
    end
  end

  always_comb begin
    prdata_o = '0;
    if (rd_en) prdata_o = sel_per ? sh_q[ch_idx].per : sh_q[ch_idx].hi;
  end

  assign shadow_o = sh_q;

  // R3: misaligned writes leave every shadow register untouched
  a_r3_unaligned_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pwrite_i && paddr_i[1:0] != 2'b00) |=> $stable(sh_q));

  // R3: misaligned reads return zero
  a_r3_unaligned_rd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paddr_i[1:0] != 2'b00) |-> (prdata_o == '0));

  // R2: no write strobe, no register change
  a_r2_no_spurious_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |=> $stable(sh_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pwm_cfg_t shadow_i,
  output logic     pwm_o
);
  pwm_cfg_t         act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             running;
  logic             last;

  assign running = (act_q.per != '0);
  assign last    = running && (cnt_q == act_q.per - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (!running) begin
      // idle: start at once when a period is pending
      if (shadow_i.per != '0) begin
        act_q <= shadow_i;
        cnt_q <= '0;
      end
    end else if (last) begin
      act_q <= shadow_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwm_o = ~running | (cnt_q < act_q.hi);

  // R6: count stays inside the period
  a_r6_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> (cnt_q < act_q.per));

  // R5: every start begins at count zero
  a_r5_start_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running) |-> (cnt_q == '0));

  // R7: working values frozen until the wrap
  a_r7_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !last) |=> $stable(act_q));

  // R8: high time covering the whole period keeps the line high
  a_r8_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && act_q.hi >= act_q.per) |-> pwm_o);

  // R4: stopped channel idles high
  a_r4_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.per == '0) |-> pwm_o);
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [CNT_W-1:0]  pwdata_i,
  output logic [CNT_W-1:0]  prdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  pwm_cfg_t [NUM_CH-1:0] shadow;

  pwm_regbank #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pwdata_i (pwdata_i),
    .prdata_o (prdata_o),
    .shadow_o (shadow)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_channel u_ch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shadow_i(shadow[c]),
        .pwm_o   (pwm_o[c])
      );
    end
  endgenerate
endmodule

// File: tb/quad_pwm_test.sv
module quad_pwm_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel_i = 1'b0;
  logic        penable_i = 1'b0;
  logic        pwrite_i = 1'b0;
  logic [4:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic [3:0]  pwm_o;

  int checks = 0;
  int errors = 0;

  quad_pwm uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
    .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pwdata_i(pwdata_i),
    .prdata_o(prdata_o), .pwm_o(pwm_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // caller sits at a falling edge; returns one falling edge later
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    psel_i = 1'b1; penable_i = 1'b1; pwrite_i = 1'b1; paddr_i = a; pwdata_i = d;
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    psel_i = 1'b1; pwrite_i = 1'b0; paddr_i = a;
    #1 d = prdata_o;
    psel_i = 1'b0;
  endtask

  // program high time first, then period; returns at first cycle of count 0
  task automatic start_ch(input int c, input logic [31:0] per, input logic [31:0] hi);
    wr(5'(c*8), hi);
    wr(5'(c*8+4), per);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 outputs high", {28'd0, pwm_o}, 32'hF);
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d);
      chk("R1 reg zero", d, 32'd0);
    end
  endtask

  task automatic t_unaligned;
    logic [31:0] d;
    wr(5'h05, 32'd7);
    repeat (3) @(negedge clk_i);
    rd(5'h04, d);
    chk("R3 unaligned write ignored", d, 32'd0);
    chk("R3 outputs untouched", {28'd0, pwm_o}, 32'hF);
    wr(5'h00, 32'd9);
    rd(5'h01, d);
    chk("R3 unaligned read zero", d, 32'd0);
    rd(5'h00, d);
    chk("R2 aligned read", d, 32'd9);
    wr(5'h00, 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    start_ch(0, 32'd5, 32'd2);
    for (int k = 0; k < 10; k++) begin
      chk("R5 R6 ch0 wave", {31'd0, pwm_o[0]}, {31'd0, (k % 5) < 2});
      chk("R9 others idle", {29'd0, pwm_o[3:1]}, 32'h7);
      @(negedge clk_i);
    end
    rd(5'h04, d);
    chk("R2 period readback", d, 32'd5);
    rd(5'h00, d);
    chk("R2 high readback", d, 32'd2);
  endtask

  task automatic t_deferred;
    logic [31:0] d;
    start_ch(2, 32'd6, 32'd3);
    chk("R6 ch2 k0", {31'd0, pwm_o[2]}, 32'd1);
    wr(5'h10, 32'd5);
    rd(5'h10, d);
    chk("R7 readback new", d, 32'd5);
    for (int k = 1; k < 12; k++) begin
      chk("R7 deferred wave", {31'd0, pwm_o[2]},
          {31'd0, (k < 6) ? (k < 3) : ((k - 6) < 5)});
      @(negedge clk_i);
    end
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(5'h10, 32'd0);
    wr(5'h14, 32'd0);
    repeat (8) @(negedge clk_i);
    for (int k = 0; k < 10; k++) begin
      chk("R4 stopped high", {31'd0, pwm_o[2]}, 32'd1);
      @(negedge clk_i);
    end
    rd(5'h14, d);
    chk("R4 period reads zero", d, 32'd0);
  endtask

  task automatic t_extremes;
    wr(5'h08, 32'd7);
    start_ch(3, 32'd4, 32'd0);
    wr(5'h0C, 32'd3);
    repeat (2) @(negedge clk_i);
    for (int k = 0; k < 9; k++) begin
      chk("R8 zero high low", {31'd0, pwm_o[3]}, 32'd0);
      chk("R8 high over period", {31'd0, pwm_o[1]}, 32'd1);
      @(negedge clk_i);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_unaligned();
        t_basic();
        t_deferred();
        t_stop();
        t_extremes();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule